// File: doc/BRIEF.md
# Burst ROM Read Controller

This block drives an external memory area that holds ROM parts able to return data in bursts. A host hands it one request at a time. Each request carries a byte start address, the ROM data width (8, 16 or 32 bits), a 3-bit burst code and a 3-bit wait count. For a read, the block raises chip select and the read strobe. It times the first access like an ordinary static-memory read with the programmed wait states. After that it moves only the address while both strobes stay active, and it returns each captured word with a one-cycle valid pulse.

A burst code of zero, or a code that the configured width does not allow, gives a single access. The illegal case also raises an error flag. A write request never bursts: it becomes one plain static-memory write cycle with the same wait timing as a first read access. All outputs are registered, and configuration inputs are sampled only when a request is accepted.

Top module: `brom_ctrl`

## Requirements
- R1: After reset, and whenever idle, `req_ready` is 1 and `bus_cs`, `bus_rd`, `bus_wr`, `rd_valid` and `done` are 0.
- R2: Width code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Burst code 0 gives one access. Codes 1, 2, 3 and 4 give 4, 8, 16 and 32 beats. The largest legal code is 4 for 8 bits, 3 for 16 bits and 2 for 32 bits.
- R3: The first beat uses the start address with its low bits cleared to the width alignment. Each later beat adds the width in bytes (1, 2 or 4), wrapping inside the block of beats×bytes that is aligned to its own size.
- R4: During a read, `bus_cs` and `bus_rd` are 1 without a gap from cycle 1 up to and including the capture cycle of the last beat. Cycle 1 is the cycle after the acceptance edge. Both are 0 in the cycle that carries `done`.
- R5: With wait count W and no stall, the first word's `rd_valid` falls in cycle W+2. Each later word follows two cycles after the previous one, and this holds for W=0 too.
- R6: With W>0, a capture cycle in which `bus_ready` is 0 is repeated and `bus_addr` stays unchanged. With W=0, `bus_ready` has no effect on timing.
- R7: `rd_data` equals `bus_din` masked to the configured width, with the upper bits zero. `rd_valid` is a one-cycle pulse per word, and `done` is 1 only together with the last word.
- R8: An illegal nonzero burst code makes `cfg_err` 1 from cycle 1 until the next acceptance and yields a single access. A legal code or a write clears it.
- R9: A write drives `bus_cs` and `bus_wr` (never `bus_rd`), with `bus_dout` equal to the write data and `bus_addr` equal to the start address. It completes with the same wait and ready timing as a first read beat, and `done` pulses in the cycle the strobes drop. It ignores the burst code and gives no `rd_valid`.
- R10: `req_ready` is 0 while a transfer is in progress, and a request presented then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte start address |
| req_width | input | 2 | ROM width code |
| req_burst | input | 3 | Burst length code |
| req_wait | input | 3 | First-access wait cycles |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 32 | Captured read word |
| done | output | 1 | Final beat / write complete pulse |
| cfg_err | output | 1 | Burst code illegal for the width |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_addr | output | 24 | Byte address to memory |
| bus_dout | output | 32 | Write data to memory |
| bus_din | input | 32 | Read data from memory |
| bus_ready | input | 1 | Memory ready |

## Verification
The hardest case to reach is a stall on a nonzero wait count that lands exactly on the capture cycle, with the wrap point of the burst block inside the same burst. From the ports this needs both the right stall timing and a start address that is not aligned to the block. The stimulus does this by lowering `bus_ready` from cycle W+1 for a chosen number of cycles, and by starting bursts part-way through their block so that the address sequence must wrap. The bench memory returns a word derived from `bus_addr`, so each captured word shows which address was driven. A zero-wait burst with `bus_ready` held low throughout shows that the ready input is ignored in that mode.

// File: rtl/brom_pkg.sv
package brom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } brom_state_t;

  // width code to log2 of bytes per beat
  function automatic logic [1:0] width_log(input logic [1:0] wcode);
    case (wcode)
      2'd0:    width_log = 2'd0;
      2'd1:    width_log = 2'd1;
      default: width_log = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/brom_cfg_decode.sv
module brom_cfg_decode #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic [1:0]        width,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  beats_m1,
  output logic [1:0]        step_log,
  output logic              err
);
  import brom_pkg::*;

  logic [CODE_W-1:0] code_max;
  logic              legal;

  always_comb begin
    step_log = width_log(width);
    // R2: widest ROM allows the fewest burst codes
    code_max = CODE_W'(4) - CODE_W'(step_log);
    legal    = (code != '0) && (code <= code_max);
    err      = (code != '0) && !legal;
    beats_m1 = legal ? CNT_W'((32'd1 << (code + 1'b1)) - 32'd1) : '0;
  end

  always_comb begin
    a_r8_err_single : assert (!(err && (beats_m1 != '0)))
      else $error("R8: illegal code decoded to a burst");
  end
endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        step_log,
  input  logic [CNT_W-1:0]  beats_m1,
  output logic [ADDR_W-1:0] addr
);
  localparam int MASK_W = CNT_W + 3;

  logic [MASK_W-1:0] blk_bytes;
  logic [ADDR_W-1:0] align_n;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] bumped;

  always_comb begin
    blk_bytes = ({{(MASK_W-CNT_W){1'b0}}, beats_m1} + MASK_W'(1)) << step_log;
    align_n   = ~((ADDR_W'(1) << step_log) - ADDR_W'(1));
    bumped    = addr + step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      mask_q <= '0;
      step_q <= '0;
    end else if (load) begin
      addr   <= start_addr & align_n;
      mask_q <= ADDR_W'(blk_bytes) - ADDR_W'(1);
      step_q <= ADDR_W'(1) << step_log;
    end else if (adv) begin
      // R3: advance by one beat, wrapping within the aligned block
      addr <= (addr & ~mask_q) | (bumped & mask_q);
    end
  end

  a_r3_wrap_in_block : assert property (@(posedge clk) disable iff (rst)
    adv |=> ((addr & ~mask_q) == $past(addr & ~mask_q)))
    else $error("R3: address left its burst block");

  a_r3_step_size : assert property (@(posedge clk) disable iff (rst)
    adv |=> (((addr - $past(addr)) & mask_q) == (step_q & mask_q)))
    else $error("R3: address step differs from width");
endmodule

// File: rtl/brom_seq.sv
module brom_seq #(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_width,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  beats_m1,
  input  logic              code_err,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              load,
  output logic              adv,
  output logic              bus_cs,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              cfg_err
);
  import brom_pkg::*;

  brom_state_t       state;
  logic [WAIT_W-1:0] wcnt;
  logic [CNT_W-1:0]  left;
  logic              wait_on;
  logic [DATA_W-1:0] wmask;
  logic              go;
  logic              hold;
  logic [DATA_W-1:0] mask_new;

  always_comb begin
    case (width_log(req_width))
      2'd0:    mask_new = DATA_W'(8'hFF);
      2'd1:    mask_new = DATA_W'(16'hFFFF);
      default: mask_new = {DATA_W{1'b1}};
    endcase
    // R6: ready only counts when wait states are programmed
    go   = (state != ST_IDLE) && (wcnt == '0) && (!wait_on || bus_ready);
    hold = (state != ST_IDLE) && (wcnt == '0) && wait_on && !bus_ready;
    load = (state == ST_IDLE) && req_valid;
    adv  = (state == ST_READ) && go && (left != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      left      <= '0;
      wait_on   <= 1'b0;
      wmask     <= '0;
      req_ready <= 1'b1;
      bus_cs    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_dout  <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            bus_cs    <= 1'b1;
            wcnt      <= req_wait;
            wait_on   <= (req_wait != '0);
            wmask     <= mask_new;
            if (req_write) begin
              // R9: writes are single plain cycles
              state    <= ST_WRITE;
              bus_wr   <= 1'b1;
              bus_dout <= req_wdata;
              left     <= '0;
              cfg_err  <= 1'b0;
            end else begin
              state   <= ST_READ;
              bus_rd  <= 1'b1;
              left    <= beats_m1;
              cfg_err <= code_err;
            end
          end
        end
        ST_READ: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (go) begin
            rd_valid <= 1'b1;
            rd_data  <= bus_din & wmask;
            if (left == '0) begin
              done      <= 1'b1;
              bus_cs    <= 1'b0;
              bus_rd    <= 1'b0;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              // R5: later beats take a setup cycle and a capture cycle
              left <= left - 1'b1;
              wcnt <= WAIT_W'(1);
            end
          end
        end
        ST_WRITE: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (go) begin
            done      <= 1'b1;
            bus_cs    <= 1'b0;
            bus_wr    <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_strobe_excl : assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr))
    else $error("R9: read and write strobes together");

  a_r4_strobe_in_cs : assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_cs)
    else $error("R4: strobe without chip select");

  a_r6_no_capture_stalled : assert property (@(posedge clk) disable iff (rst)
    hold |=> !rd_valid)
    else $error("R6: word captured while not ready");

  a_r5_beat_gap : assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !done) |=> !rd_valid)
    else $error("R5: later beat faster than two cycles");

  a_r4_release_on_done : assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cs && req_ready))
    else $error("R4: strobes still active with done");

  a_r10_busy_not_ready : assert property (@(posedge clk) disable iff (rst)
    bus_cs |-> !req_ready)
    else $error("R10: ready while busy");
endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 3,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_width,
  input  logic [CODE_W-1:0] req_burst,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              cfg_err,
  output logic              bus_cs,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ready
);
  localparam int CNT_W = 5;

  logic [CNT_W-1:0] beats_m1;
  logic [CNT_W-1:0] beats_use;
  logic [1:0]       step_log;
  logic             code_err;
  logic             load;
  logic             adv;

  brom_cfg_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .width    (req_width),
    .code     (req_burst),
    .beats_m1 (beats_m1),
    .step_log (step_log),
    .err      (code_err)
  );

  // writes never burst, so their block is one beat
  assign beats_use = req_write ? '0 : beats_m1;

  brom_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .adv        (adv),
    .start_addr (req_addr),
    .step_log   (step_log),
    .beats_m1   (beats_use),
    .addr       (bus_addr)
  );

  brom_seq #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_width (req_width),
    .req_wait  (req_wait),
    .req_wdata (req_wdata),
    .beats_m1  (beats_use),
    .code_err  (code_err),
    .bus_ready (bus_ready),
    .bus_din   (bus_din),
    .req_ready (req_ready),
    .load      (load),
    .adv       (adv),
    .bus_cs    (bus_cs),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_dout  (bus_dout),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .done      (done),
    .cfg_err   (cfg_err)
  );

  a_r6_addr_held : assert property (@(posedge clk) disable iff (rst)
    (bus_cs && !bus_ready && !rd_valid && !done && $stable(bus_cs) && !adv && !load)
      |=> $stable(bus_addr))
    else $error("R6: address moved during a stall");
endmodule

// File: tb/brom_ctrl_tb.sv
`timescale 1ns/1ps
module brom_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_width = '0;
  logic [2:0]  req_burst = '0;
  logic [2:0]  req_wait = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done;
  logic        cfg_err;
  logic        bus_cs, bus_rd, bus_wr;
  logic [23:0] bus_addr;
  logic [31:0] bus_dout;
  logic [31:0] bus_din;
  logic        bus_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rom_word(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h33, ~a[7:0], a[7:0]};
  endfunction

  assign bus_din = rom_word(bus_addr);

  brom_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_width(req_width),
    .req_burst(req_burst), .req_wait(req_wait), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .cfg_err(cfg_err),
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [23:0] a, input logic [1:0] w,
                       input logic [2:0] code, input logic [2:0] wt,
                       input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_width = w;
    req_burst = code; req_wait = wt; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(req_ready && !bus_cs && !bus_rd && !bus_wr && !rd_valid && !done,
        "R1", "idle outputs", {26'd0, req_ready, bus_cs, bus_rd, bus_wr, rd_valid, done},
        32'h20);
  endtask

  // one read transfer; checks every cycle from 1 to a few past done
  task automatic do_read(input logic [23:0] a, input logic [1:0] w,
                         input logic [2:0] code, input logic [2:0] wt,
                         input int stall, input bit rdy_low, input bit poke);
    int wl, step, maxc, nb, first_n, last_n, mask, k;
    bit legal, exp_err;
    logic [23:0] base, ea;
    logic [31:0] wm;
    wl   = (w == 2'd0) ? 0 : (w == 2'd1) ? 1 : 2;
    step = 1 << wl;
    maxc = 4 - wl;
    legal   = (code >= 1) && (code <= maxc);
    exp_err = (code != 0) && !legal;
    nb   = legal ? (1 << (code + 1)) : 1;
    mask = nb * step - 1;
    base = a & ~(24'(step) - 24'd1);
    wm   = (wl == 0) ? 32'hFF : (wl == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    first_n = wt + 2 + ((wt > 0) ? stall : 0);
    last_n  = first_n + 2 * (nb - 1);
    issue(1'b0, a, w, code, wt, 32'd0);
    for (int n = 1; n <= last_n + 3; n++) begin
      if (rdy_low) bus_ready = 1'b0;
      else bus_ready = !((n >= wt + 1) && (n < wt + 1 + stall));
      if (poke) req_valid = (n == 2);
      if (poke && n == 2) begin req_write = 1'b1; req_addr = 24'hABCDE0; end
      #1;
      if (n == 1) begin
        chk(cfg_err == exp_err, "R8", "error flag", {31'd0, cfg_err}, {31'd0, exp_err});
        chk(bus_addr == base, "R3", "first address", {8'd0, bus_addr}, {8'd0, base});
        chk(!req_ready, "R10", "busy ready", {31'd0, req_ready}, 32'd0);
      end
      if (wt > 0 && n >= wt + 1 && n <= wt + stall && stall > 0)
        chk(bus_addr == base, "R6", "stall address", {8'd0, bus_addr}, {8'd0, base});
      chk((bus_cs == (n < last_n)) && (bus_rd == (n < last_n)) && !bus_wr,
          "R4", "strobes", {29'd0, bus_cs, bus_rd, bus_wr},
          {29'd0, (n < last_n), (n < last_n), 1'b0});
      k = (n - first_n) / 2;
      if (n >= first_n && n <= last_n && ((n - first_n) % 2 == 0)) begin
        ea = (base & ~24'(mask)) | ((base + 24'(k * step)) & 24'(mask));
        chk(rd_valid, "R5", "valid timing", {31'd0, rd_valid}, 32'd1);
        chk(rd_data == (rom_word(ea) & wm), "R7", "read data", rd_data, rom_word(ea) & wm);
        chk(done == (n == last_n), "R7", "done flag", {31'd0, done}, {31'd0, (n == last_n)});
      end else begin
        chk(!rd_valid && !done, "R5", "no pulse", {30'd0, rd_valid, done}, 32'd0);
      end
      @(negedge clk);
    end
    bus_ready = 1'b1;
    req_valid = 1'b0;
    req_write = 1'b0;
    if (poke) chk(!bus_cs && req_ready, "R10", "busy request dropped",
                  {30'd0, bus_cs, req_ready}, 32'd1);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [2:0] wt,
                          input int stall, input logic [31:0] wd);
    int last_n;
    last_n = wt + 2 + ((wt > 0) ? stall : 0);
    issue(1'b1, a, 2'd0, 3'd4, wt, wd);
    for (int n = 1; n <= last_n + 2; n++) begin
      bus_ready = !((n >= wt + 1) && (n < wt + 1 + stall));
      #1;
      if (n == 1) begin
        chk(bus_dout == wd, "R9", "write data", bus_dout, wd);
        chk(bus_addr == a, "R9", "write address", {8'd0, bus_addr}, {8'd0, a});
        chk(!cfg_err, "R9", "no error on write", {31'd0, cfg_err}, 32'd0);
      end
      chk((bus_cs == (n < last_n)) && (bus_wr == (n < last_n)) && !bus_rd && !rd_valid,
          "R9", "write strobes", {28'd0, bus_cs, bus_wr, bus_rd, rd_valid},
          {28'd0, (n < last_n), (n < last_n), 2'b00});
      chk(done == (n == last_n), "R9", "write done", {31'd0, done}, {31'd0, (n == last_n)});
      @(negedge clk);
    end
    bus_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    test_reset();                                    // R1
    do_read(24'h000105, 2'd0, 3'd4, 3'd0, 0, 1'b0, 1'b0); // R2 R3 R5: 32 beats wrap
    do_read(24'h00203A, 2'd1, 3'd3, 3'd2, 3, 1'b0, 1'b0); // R6 stall, 16 beats
    do_read(24'h00301E, 2'd2, 3'd2, 3'd1, 0, 1'b0, 1'b0); // R3 align, 32-bit
    do_read(24'h004010, 2'd2, 3'd3, 3'd0, 0, 1'b1, 1'b0); // R8 illegal, R6 ready ignored
    do_read(24'h005007, 2'd0, 3'd0, 3'd3, 0, 1'b0, 1'b0); // R2 single, R8 cleared
    do_read(24'h006000, 2'd0, 3'd5, 3'd0, 0, 1'b0, 1'b0); // R8 code 5
    do_write(24'h007123, 3'd2, 2, 32'hDEADBEEF);         // R9
    do_write(24'h007200, 3'd0, 0, 32'h12345678);         // R9 zero wait
    do_read(24'h008002, 2'd1, 3'd1, 3'd0, 0, 1'b0, 1'b1); // R10 busy poke
    test_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule